// File: doc/BRIEF.md
# Leakage-Binned Body-Bias Calibrator

This controller decides which body-bias mode a memory array should run in, based on a single reading of the array's total leakage. An external monitor turns the array's leakage current into a voltage. Two comparators test that voltage against an upper and a lower reference level and return two bits. High leakage puts the voltage above both references, which marks a low-threshold die. For that die the controller selects reverse bias. Low leakage leaves the voltage below both references, which marks a high-threshold die, and forward bias is selected. A reading between the two references marks a nominal die and keeps zero bias.

A calibration starts when `cal_req` is seen while the controller is idle. The controller opens the monitor's bypass switch so the monitor sits in the supply path, and it waits a programmable number of settling cycles. It then samples the synchronized comparator bits and closes the bypass again. If the decoded mode differs from the current one, all three bias selects drop for one cycle before the new select is raised. The chosen mode is held until the next calibration.

The state machine has four states. `ST_IDLE` holds the mode with the bypass closed. `ST_SETTLE` counts down the settling window with the monitor inserted. `ST_SAMPLE` decodes the reading, still with the monitor inserted. `ST_BREAK` is a single cycle with every select low. The transitions are:
- idle to settle on an accepted request;
- settle to sample when the count expires;
- sample to break when the mode changes, or sample to idle when it does not;
- break to idle, which loads the new mode.

Top module: `bbias_cal_top`

## Requirements
- R1: After reset `mon_insert` is 0, `bias_zero` is 1, `bias_rev` and `bias_fwd` are 0, and `cal_fault` is 0.
- R2: A request accepted at a clock edge raises `mon_insert` from the next cycle. It stays high for exactly `settle_cycles`+2 consecutive cycles. It is low at all other times.
- R3: A sampled pair with `mon_above_hi`=1 and `mon_above_lo`=1 (a low-threshold die) selects reverse bias, so `bias_rev` is the only select high.
- R4: A sampled pair with `mon_above_hi`=0 and `mon_above_lo`=1 (a nominal die) selects zero bias, so `bias_zero` is the only select high, and `cal_fault` is 0.
- R5: A sampled pair with `mon_above_hi`=0 and `mon_above_lo`=0 (a high-threshold die) selects forward bias, so `bias_fwd` is the only select high.
- R6: A sampled pair with `mon_above_hi`=1 and `mon_above_lo`=0 is invalid. It selects zero bias and sets `cal_fault`. `cal_fault` keeps its value until the next sample.
- R7: At most one of the three selects is high in any cycle. Exactly one is high in every cycle except a break cycle.
- R8: When the mode changes, every select is low in exactly one cycle, the cycle `settle_cycles`+3 after acceptance, and the new select is high from the next cycle. When the mode does not change, there is no low cycle.
- R9: Between calibrations the selected mode and `cal_fault` do not follow changes on the comparator inputs.
- R10: `cal_req` has no effect while a calibration is in progress. The monitor window is not extended or restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibration request, sampled only when idle |
| settle_cycles | input | CNT_W | Settling count loaded when a request is accepted |
| mon_above_hi | input | 1 | Comparator: monitor voltage above the upper reference |
| mon_above_lo | input | 1 | Comparator: monitor voltage above the lower reference |
| mon_insert | output | 1 | 1 opens the bypass switch, which places the monitor in the supply path |
| bias_rev | output | 1 | Reverse body-bias select |
| bias_zero | output | 1 | Zero body-bias select |
| bias_fwd | output | 1 | Forward body-bias select |
| cal_fault | output | 1 | Last sampled comparator pair was invalid |

## Verification
The assertions assume three things about the inputs. The comparator bits are quasi-static, and they are stable for at least the synchronizer depth before the sample cycle. `settle_cycles` does not change during a calibration. `cal_req` is a plain level. The bench sets the comparator pair and the settling count several cycles before it raises the request and holds them until the controller is idle again. It changes the comparator pair only between calibrations, where R9 says the change must be ignored, and it pulses the request in the middle of a settling window to exercise R10.

// File: rtl/bbias_cal_pkg.sv
package bbias_cal_pkg;

    typedef enum logic [1:0] {
        BIAS_REV  = 2'd0,
        BIAS_ZERO = 2'd1,
        BIAS_FWD  = 2'd2
    } bias_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_BREAK  = 2'd3
    } cal_state_t;

    // select vector order: {fwd, zero, rev}
    function automatic logic [2:0] mode_to_sel(input bias_mode_t m);
        logic [2:0] s;
        unique case (m)
            BIAS_REV:  s = 3'b001;
            BIAS_ZERO: s = 3'b010;
            BIAS_FWD:  s = 3'b100;
            default:   s = 3'b010;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bbias_cmp_sync.sv
module bbias_cmp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bbias_settle_cnt.sv
module bbias_settle_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2
    cnt_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && expired) |=> expired);
endmodule

// File: rtl/bbias_corner_dec.sv
module bbias_corner_dec
    import bbias_cal_pkg::*;
(
    input  logic       above_hi,
    input  logic       above_lo,
    output bias_mode_t mode,
    output logic       invalid
);
    always_comb begin
        unique case ({above_hi, above_lo})
            2'b11:   begin mode = BIAS_REV;  invalid = 1'b0; end
            2'b01:   begin mode = BIAS_ZERO; invalid = 1'b0; end
            2'b00:   begin mode = BIAS_FWD;  invalid = 1'b0; end
            default: begin mode = BIAS_ZERO; invalid = 1'b1; end
        endcase
    end
endmodule

// File: rtl/bbias_cal_top.sv
module bbias_cal_top
    import bbias_cal_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_req,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic             mon_above_hi,
    input  logic             mon_above_lo,
    output logic             mon_insert,
    output logic             bias_rev,
    output logic             bias_zero,
    output logic             bias_fwd,
    output logic             cal_fault
);
    cal_state_t state_q, state_d;
    bias_mode_t mode_q, pend_q, dec_mode;
    logic       err_q, dec_invalid, expired;
    logic [1:0] cmp_sync;
    logic [2:0] sel;

    bbias_cmp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mon_above_hi, mon_above_lo}),
        .q     (cmp_sync)
    );

    bbias_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_IDLE && cal_req),
        .load_val (settle_cycles),
        .run      (state_q == ST_SETTLE),
        .expired  (expired)
    );

    bbias_corner_dec u_dec (
        .above_hi (cmp_sync[1]),
        .above_lo (cmp_sync[0]),
        .mode     (dec_mode),
        .invalid  (dec_invalid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cal_req) state_d = ST_SETTLE;
            ST_SETTLE: if (expired) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = (dec_mode != mode_q) ? ST_BREAK : ST_IDLE;
            ST_BREAK:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= BIAS_ZERO;
            pend_q  <= BIAS_ZERO;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SAMPLE) begin
                pend_q <= dec_mode;
                err_q  <= dec_invalid;
            end
            if (state_q == ST_BREAK) mode_q <= pend_q;
        end
    end

    // outputs
    always_comb begin
        mon_insert = 1'b0;
        sel        = mode_to_sel(mode_q);
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: mon_insert = 1'b1;
            ST_SAMPLE: mon_insert = 1'b1;
            ST_BREAK:  sel = 3'b000;
            default:   ;
        endcase
    end

    assign bias_rev  = sel[0];
    assign bias_zero = sel[1];
    assign bias_fwd  = sel[2];
    assign cal_fault = err_q;

    // R2, R10
    mon_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_insert) |-> $past(cal_req));

    // R7
    sel_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bias_fwd, bias_zero, bias_rev}));

    // R7
    break_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({bias_fwd, bias_zero, bias_rev} == 3'b000) |=> ({bias_fwd, bias_zero, bias_rev} != 3'b000));

    // R8
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past({bias_fwd, bias_zero, bias_rev}) != 3'b000) && ({bias_fwd, bias_zero, bias_rev} != 3'b000))
        |-> $stable({bias_fwd, bias_zero, bias_rev}));

    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fault |-> (bias_zero || {bias_fwd, bias_rev} == 2'b00) && !bias_fwd && !bias_rev);

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_insert && $past(!mon_insert) && {bias_fwd, bias_zero, bias_rev} != 3'b000
         && $past({bias_fwd, bias_zero, bias_rev}) != 3'b000)
        |-> ($stable({bias_fwd, bias_zero, bias_rev}) && $stable(cal_fault)));
endmodule

// File: tb/bbias_cal_top_tb_top.sv
module bbias_cal_top_tb_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cal_req = 1'b0;
    logic [CNT_W-1:0] settle_cycles = '0;
    logic             mon_above_hi = 1'b0;
    logic             mon_above_lo = 1'b1;
    logic             mon_insert, bias_rev, bias_zero, bias_fwd, cal_fault;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bbias_cal_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cal_req       (cal_req),
        .settle_cycles (settle_cycles),
        .mon_above_hi  (mon_above_hi),
        .mon_above_lo  (mon_above_lo),
        .mon_insert    (mon_insert),
        .bias_rev      (bias_rev),
        .bias_zero     (bias_zero),
        .bias_fwd      (bias_fwd),
        .cal_fault     (cal_fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // select vector {fwd, zero, rev} expected for a comparator pair
    function automatic logic [2:0] exp_sel(input logic hi, input logic lo);
        if (hi && lo)        return 3'b001;
        else if (!hi && lo)  return 3'b010;
        else if (!hi && !lo) return 3'b100;
        else                 return 3'b010;
    endfunction

    logic [2:0] cur_sel = 3'b010;

    task automatic run_cal(input logic hi, input logic lo, input int n, input int busy_at);
        int mon_cnt = 0, mon_first = 0, mon_last = 0;
        int zero_cnt = 0, zero_idx = 0, multi = 0;
        logic [2:0] want, got;
        @(negedge clk);
        mon_above_hi  = hi;
        mon_above_lo  = lo;
        settle_cycles = CNT_W'(n);
        repeat (3) @(negedge clk);
        cal_req = 1'b1;
        for (int i = 1; i <= n + 8; i++) begin
            @(negedge clk);
            if (i == 1) cal_req = 1'b0;
            if (busy_at > 0 && i == busy_at) cal_req = 1'b1;
            if (busy_at > 0 && i == busy_at + 1) cal_req = 1'b0;
            got = {bias_fwd, bias_zero, bias_rev};
            if ($countones(got) > 1) multi++;
            if (got == 3'b000) begin zero_cnt++; zero_idx = i; end
            if (mon_insert) begin
                mon_cnt++;
                if (mon_first == 0) mon_first = i;
                mon_last = i;
            end
        end
        want = exp_sel(hi, lo);
        chk(mon_cnt == n + 2, "R2 monitor window length", mon_cnt, n + 2);
        chk(mon_first == 1 && mon_last == n + 2, "R2 monitor window position", mon_first, 1);
        if (busy_at > 0)
            chk(mon_cnt == n + 2, "R10 request ignored while busy", mon_cnt, n + 2);
        chk(multi == 0, "R7 at most one select", multi, 0);
        if (want != cur_sel) begin
            chk(zero_cnt == 1, "R8 one break cycle on change", zero_cnt, 1);
            chk(zero_idx == n + 3, "R8 break cycle position", zero_idx, n + 3);
        end else begin
            chk(zero_cnt == 0, "R8 no break without change", zero_cnt, 0);
        end
        got = {bias_fwd, bias_zero, bias_rev};
        if (hi && lo)        chk(got == want, "R3 reverse bias on low threshold", int'(got), int'(want));
        else if (!hi && lo)  chk(got == want && !cal_fault, "R4 zero bias on nominal", int'({cal_fault, got}), int'(want));
        else if (!hi && !lo) chk(got == want, "R5 forward bias on high threshold", int'(got), int'(want));
        else                 chk(got == want, "R6 zero bias on invalid pair", int'(got), int'(want));
        chk(cal_fault == (hi && !lo), "R6 fault flag", int'(cal_fault), int'(hi && !lo));
        cur_sel = want;
    endtask

    task automatic check_hold(input logic hi, input logic lo);
        logic [2:0] got;
        logic f0;
        f0 = cal_fault;
        @(negedge clk);
        mon_above_hi = hi;
        mon_above_lo = lo;
        repeat (12) @(negedge clk);
        got = {bias_fwd, bias_zero, bias_rev};
        chk(got == cur_sel, "R9 mode held between calibrations", int'(got), int'(cur_sel));
        chk(cal_fault == f0 && !mon_insert, "R9 fault held and monitor bypassed", int'({mon_insert, cal_fault}), int'(f0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mon_insert == 1'b0, "R1 reset monitor bypassed", int'(mon_insert), 0);
        chk({bias_fwd, bias_zero, bias_rev} == 3'b010, "R1 reset zero bias",
            int'({bias_fwd, bias_zero, bias_rev}), 2);
        chk(cal_fault == 1'b0, "R1 reset fault clear", int'(cal_fault), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({mon_insert, bias_fwd, bias_zero, bias_rev, cal_fault} == 5'b00100, "R1 idle after reset",
            int'({mon_insert, bias_fwd, bias_zero, bias_rev, cal_fault}), 4);
        foreach (settle_list[k]) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    run_cal(a[1], a[0], settle_list[k], 0);
                    run_cal(b[1], b[0], settle_list[k], 0);
                end
            end
        end
        run_cal(1'b1, 1'b1, 6, 3);
        check_hold(1'b0, 1'b0);
        run_cal(1'b0, 1'b0, 9, 5);
        check_hold(1'b1, 1'b0);
        run_cal(1'b1, 1'b0, 2, 0);
        check_hold(1'b1, 1'b1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int settle_list [4] = '{0, 1, 2, 5};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule